// File: doc/BRIEF.md
# Bus Command Ready Timer

This block sits in the bus controller and decides when a command cycle on a 16-bit expansion bus is over. When a command starts, a wait-state counter runs on the bus clock. If the addressed target does nothing, the cycle ends once a parameterised number of bus clocks has passed. The target has two ways to change this. It can drive the ready line low to stretch the cycle, which freezes the count until ready returns high. It can also raise its no-wait request, which ends the cycle at the next clock.

While ready is low the no-wait request has no effect, so a target that stretches a cycle always wins over a shortening request. A watchdog counts consecutive bus clocks with ready held low. When that count reaches a parameterised limit, the watchdog forces the cycle to end and raises a timeout flag. The flag stays high until the next command is accepted.

The end of a cycle is a single-clock strobe. Afterwards the block is idle and accepts the next command start. An option, chosen when the block is built, registers the two target inputs before they are used. This adds one clock of latency to their effect. Address latching, data steering and command line generation are handled elsewhere.

Top module: `isa_ready_timer`

## Requirements
- R1: After reset, `cyc_end` and `hold_timeout` are 0 and the block is idle.
- R2: With `tgt_ready` high and `tgt_nowait` low, `cyc_end` is high in the cycle after the WAIT_CNT-th rising edge following the edge that sampled `cmd_start` while idle.
- R3: `cyc_end` is high for exactly one cycle per command, and the block is idle afterwards.
- R4: Each rising edge of an active cycle that samples `tgt_ready` low adds one clock to the cycle. The elapsed count is kept while ready is low and resumes when ready returns high; it does not restart.
- R5: `tgt_nowait` high with `tgt_ready` high at a rising edge of an active cycle ends the cycle at that edge.
- R6: `tgt_nowait` has no effect at any edge where `tgt_ready` is low.
- R7: HOLD_LIMIT consecutive edges with `tgt_ready` low in an active cycle end the cycle at the last of those edges and set `hold_timeout`. With one fewer low edge, the cycle ends normally and `hold_timeout` stays 0.
- R8: `hold_timeout` stays high while idle and falls at the edge that accepts the next `cmd_start`.
- R9: `cmd_start` during an active cycle is ignored. A `cmd_start` presented while `cyc_end` is high is accepted.
- R10: While idle, `tgt_nowait` produces no `cyc_end`, and `tgt_ready` low does not count toward the watchdog.
- R11: An edge with `tgt_ready` high clears the consecutive-low count of the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Command start strobe, sampled on the rising edge |
| tgt_ready | input | 1 | Target ready; low stretches the cycle |
| tgt_nowait | input | 1 | Target no-wait request, active high |
| cyc_end | output | 1 | One-clock end-of-cycle strobe |
| hold_timeout | output | 1 | Ready held low too long; stays high until the next start |

## Verification
Two clashes between functions are tested. The first is the no-wait request arriving while ready is low. The bench raises both inputs together for several edges and then releases ready with the request still high. The cycle must not end until the edge where ready is high, and it must end exactly there. The second clash is a new command start that arrives in the same cycle as the end strobe. The bench drives the start in that cycle and expects a full default-length second cycle measured from the next edge. Both cases are judged by counting clocks from the start edge to the strobe.

// File: rtl/isa_rdy_pkg.sv
package isa_rdy_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } cyc_state_e;

   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rdy_input_stage.sv
module rdy_input_stage #(
   parameter bit IN_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ready_in,
   input  logic nowait_in,
   output logic ready_out,
   output logic nowait_out
);

   generate
      if (IN_REG) begin : g_reg
         logic ready_q;
         logic nowait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ready_q  <= 1'b1;
               nowait_q <= 1'b0;
            end else begin
               ready_q  <= ready_in;
               nowait_q <= nowait_in;
            end
         end
         assign ready_out  = ready_q;
         assign nowait_out = nowait_q;
      end else begin : g_pass
         assign ready_out  = ready_in;
         assign nowait_out = nowait_in;
      end
   endgenerate

endmodule

// File: rtl/rdy_wait_counter.sv
module rdy_wait_counter #(
   parameter int WAIT_CNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic at_last
);
   import isa_rdy_pkg::*;

   localparam int CW = cnt_width(WAIT_CNT);
   localparam logic [CW-1:0] LAST = CW'(WAIT_CNT - 1);

   generate
      if (WAIT_CNT < 1) begin : g_bad_wait
         $error("WAIT_CNT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] elapsed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         elapsed <= '0;
      else if (clear)
         elapsed <= '0;
      else if (advance && elapsed != LAST)
         elapsed <= elapsed + 1'b1;
   end

   assign at_last = (elapsed == LAST);

   a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      elapsed <= LAST);

   a_r4_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !advance) |=> $stable(elapsed));

endmodule

// File: rtl/rdy_hold_watchdog.sv
module rdy_hold_watchdog #(
   parameter int HOLD_LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic count_en,
   output logic limit_hit
);
   import isa_rdy_pkg::*;

   localparam int HW = cnt_width(HOLD_LIMIT);
   localparam logic [HW-1:0] TOP = HW'(HOLD_LIMIT - 1);

   generate
      if (HOLD_LIMIT < 2) begin : g_bad_limit
         $error("HOLD_LIMIT must be at least 2");
      end
   endgenerate

   logic [HW-1:0] lows;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lows <= '0;
      else if (clear)
         lows <= '0;
      else if (count_en && lows != TOP)
         lows <= lows + 1'b1;
   end

   assign limit_hit = count_en && (lows == TOP);

   a_r7_hold_range: assert property (@(posedge clk) disable iff (!rst_n)
      lows <= TOP);

   a_r11_hold_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (lows == '0));

endmodule

// File: rtl/isa_ready_timer.sv
module isa_ready_timer #(
   parameter int WAIT_CNT   = 4,
   parameter int HOLD_LIMIT = 1024,
   parameter bit IN_REG     = 1'b0
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic cmd_start,
   input  logic tgt_ready,
   input  logic tgt_nowait,
   output logic cyc_end,
   output logic hold_timeout
);
   import isa_rdy_pkg::*;

   cyc_state_e state_q;
   logic rdy_s, nows_s;
   logic busy, stall, at_last, limit_hit;
   logic end_now, end_by_hold, accept;
   logic cyc_end_q, timeout_q;

   rdy_input_stage #(.IN_REG(IN_REG)) u_in (
      .clk        (bclk),
      .rst_n      (rst_n),
      .ready_in   (tgt_ready),
      .nowait_in  (tgt_nowait),
      .ready_out  (rdy_s),
      .nowait_out (nows_s)
   );

   assign busy   = (state_q == ST_BUSY);
   assign stall  = busy && !rdy_s;
   assign accept = !busy && cmd_start;

   assign end_by_hold = stall && limit_hit;
   assign end_now     = (busy && rdy_s && (nows_s || at_last)) || end_by_hold;

   rdy_wait_counter #(.WAIT_CNT(WAIT_CNT)) u_wait (
      .clk     (bclk),
      .rst_n   (rst_n),
      .clear   (!busy || end_now),
      .advance (busy && rdy_s),
      .at_last (at_last)
   );

   rdy_hold_watchdog #(.HOLD_LIMIT(HOLD_LIMIT)) u_hold (
      .clk       (bclk),
      .rst_n     (rst_n),
      .clear     (!stall || end_now),
      .count_en  (stall),
      .limit_hit (limit_hit)
   );

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cyc_end_q <= 1'b0;
         timeout_q <= 1'b0;
      end else begin
         cyc_end_q <= end_now;
         case (state_q)
            ST_IDLE: if (accept) state_q <= ST_BUSY;
            ST_BUSY: if (end_now) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
         if (accept)
            timeout_q <= 1'b0;
         else if (end_by_hold)
            timeout_q <= 1'b1;
      end
   end

   assign cyc_end      = cyc_end_q;
   assign hold_timeout = timeout_q;

   a_r3_single_pulse: assert property (@(posedge bclk) disable iff (!rst_n)
      cyc_end |=> !cyc_end);

   a_r10_idle_no_end: assert property (@(posedge bclk) disable iff (!rst_n)
      !busy |=> !cyc_end);

   a_r4_stall_holds: assert property (@(posedge bclk) disable iff (!rst_n)
      (stall && !limit_hit) |=> (!cyc_end && busy));

   a_r7_timeout_with_end: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(hold_timeout) |-> cyc_end);

   a_r8_timeout_clear: assert property (@(posedge bclk) disable iff (!rst_n)
      accept |=> !hold_timeout);

   a_r9_start_ignored: assert property (@(posedge bclk) disable iff (!rst_n)
      (busy && !end_now) |=> busy);

endmodule

// File: tb/tb_isa_ready_timer.sv
module tb_isa_ready_timer;

   localparam int CLK_PERIOD = 10;
   localparam int WAIT_CNT   = 4;
   localparam int HOLD_LIMIT = 8;
   localparam int NVEC       = 8;
   localparam int MAXK       = 24;

   logic bclk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_start = 1'b0;
   logic tgt_ready = 1'b1;
   logic tgt_nowait = 1'b0;
   logic cyc_end, hold_timeout;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) bclk = ~bclk;

   isa_ready_timer #(.WAIT_CNT(WAIT_CNT), .HOLD_LIMIT(HOLD_LIMIT), .IN_REG(1'b0)) dut (
      .bclk(bclk), .rst_n(rst_n), .cmd_start(cmd_start), .tgt_ready(tgt_ready),
      .tgt_nowait(tgt_nowait), .cyc_end(cyc_end), .hold_timeout(hold_timeout)
   );

   // vector: {ready pattern, nowait pattern, expected end edge, expected timeout, tag}
   // bit k-1 of each pattern is the level presented to edge k after the start edge
   typedef struct packed {
      logic [31:0] rdy;
      logic [31:0] nw;
      logic [7:0]  exp_k;
      logic        exp_to;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{32'hFFFF_FFFF, 32'h0000_0000, 8'd4,  1'b0},  // R2 default length
      '{32'hFFFF_FFFF, 32'h0000_0001, 8'd1,  1'b0},  // R5 no-wait
      '{32'hFFFF_FFFC, 32'h0000_0000, 8'd6,  1'b0},  // R4 stretch at start
      '{32'hFFFF_FFF9, 32'h0000_0000, 8'd6,  1'b0},  // R4 stretch mid-cycle
      '{32'hFFFF_FFFC, 32'h0000_0007, 8'd3,  1'b0},  // R6 no-wait under stretch
      '{32'hFFFF_FF00, 32'h0000_0000, 8'd8,  1'b1},  // R7 hold limit
      '{32'hFFFF_0080, 32'h0000_0000, 8'd16, 1'b1},  // R11 watchdog restart
      '{32'hFFFF_FF80, 32'h0000_0000, 8'd11, 1'b0}   // R7 one below limit
   };

   localparam string TAGS [NVEC] = '{"R2", "R5", "R4", "R4", "R6", "R7", "R11", "R7"};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // starts a command and returns the edge index at which cyc_end was seen (0 = none)
   task automatic run_cmd(input logic [31:0] rp, input logic [31:0] np,
                          input int start_again_at, output int got);
      got = 0;
      @(negedge bclk);
      cmd_start = 1'b1; tgt_ready = 1'b1; tgt_nowait = 1'b0;
      @(negedge bclk);
      cmd_start = 1'b0;
      for (int k = 1; k <= MAXK; k++) begin
         tgt_ready  = rp[k-1];
         tgt_nowait = np[k-1];
         cmd_start  = (k == start_again_at);
         @(negedge bclk);
         cmd_start = 1'b0;
         if (cyc_end) begin
            got = k;
            break;
         end
      end
      tgt_ready = 1'b1; tgt_nowait = 1'b0;
   endtask

   initial begin
      int got;
      int cnt;
      repeat (3) @(negedge bclk);
      // R1 reset state
      check(cyc_end == 1'b0, "R1", cyc_end, 0);
      check(hold_timeout == 1'b0, "R1", hold_timeout, 0);
      rst_n = 1'b1;
      @(negedge bclk);
      check(cyc_end == 1'b0, "R1", cyc_end, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         run_cmd(VECS[v].rdy, VECS[v].nw, 0, got);
         check(got == int'(VECS[v].exp_k), TAGS[v], got, int'(VECS[v].exp_k));
         check(hold_timeout == VECS[v].exp_to, TAGS[v], hold_timeout, VECS[v].exp_to);
         @(negedge bclk);
         check(cyc_end == 1'b0, "R3", cyc_end, 0);
      end

      // R8: timeout stays while idle, clears when the next start is accepted
      run_cmd(32'hFFFF_FF00, 32'h0, 0, got);
      repeat (3) @(negedge bclk);
      check(hold_timeout == 1'b1, "R8", hold_timeout, 1);
      cmd_start = 1'b1;
      @(negedge bclk);
      cmd_start = 1'b0;
      check(hold_timeout == 1'b0, "R8", hold_timeout, 0);
      repeat (WAIT_CNT + 2) @(negedge bclk);

      // R10: no-wait while idle gives no end strobe
      cnt = 0;
      tgt_nowait = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge bclk);
         if (cyc_end) cnt++;
      end
      tgt_nowait = 1'b0;
      check(cnt == 0, "R10", cnt, 0);

      // R10: ready low while idle does not load the watchdog
      tgt_ready = 1'b0;
      repeat (HOLD_LIMIT + 4) @(negedge bclk);
      run_cmd(32'hFFFF_FFFE, 32'h0, 0, got);
      check(got == WAIT_CNT + 1, "R10", got, WAIT_CNT + 1);
      check(hold_timeout == 1'b0, "R10", hold_timeout, 0);

      // R9: start during an active cycle is ignored
      run_cmd(32'hFFFF_FFFF, 32'h0, 2, got);
      check(got == WAIT_CNT, "R9", got, WAIT_CNT);
      @(negedge bclk);
      check(cyc_end == 1'b0, "R9", cyc_end, 0);

      // R9: start presented while cyc_end is high is accepted
      run_cmd(32'hFFFF_FFFF, 32'h0, 0, got);
      check(got == WAIT_CNT, "R9", got, WAIT_CNT);
      cmd_start = 1'b1;
      @(negedge bclk);
      cmd_start = 1'b0;
      got = 0;
      for (int k = 1; k <= MAXK; k++) begin
         @(negedge bclk);
         if (cyc_end) begin
            got = k;
            break;
         end
      end
      check(got == WAIT_CNT, "R9", got, WAIT_CNT);

      // R3: nothing further after the pulse
      cnt = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge bclk);
         if (cyc_end) cnt++;
      end
      check(cnt == 0, "R3", cnt, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge bclk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule